// File: doc/BRIEF.md
# Pipelined Word and Byte Memory Port

This block sits between a microcoded datapath and main memory. It offers two separate access paths. The word path takes its address from the address register and its data from the data register. It performs reads and writes of full 32-bit words. The byte path takes its address from the program counter and performs instruction fetches only, returning one byte for the 8-bit byte buffer.

The current microinstruction raises read, write or fetch requests in some cycle k. The port captures the request together with the register contents at the end of cycle k and drives memory during cycle k+1. In that same cycle it raises a load pulse that carries the returned value to the datapath, and the datapath register captures it at the edge that ends k+1. A value read in cycle k is therefore usable from cycle k+2, and the target register keeps its old contents until then.

Requests may be issued in consecutive cycles. A word access and a byte fetch may overlap freely. Word addresses become byte addresses through a left shift by the log2 of the word size. A read and a write issued together are refused and flagged.

Top module: `mem_port_pipe`

## Requirements
- R1: After reset, mem_rd, mem_wr, mem_fetch, mdr_load, mbr_load and req_conflict are all 0.
- R2: A read request alone in cycle k drives mem_rd=1 in cycle k+1, with mem_waddr equal to the cycle-k mar_in shifted left by 2 (the byte address of the word).
- R3: For a read issued in cycle k, mdr_load=1 in cycle k+1 and mdr_data carries the memory word. A datapath register loaded by this pulse holds its previous value throughout cycle k+1 and the new word from cycle k+2.
- R4: Reads in cycles k and k+1 produce load pulses in cycles k+1 and k+2, each carrying the word from its own address.
- R5: A write request alone in cycle k drives mem_wr=1 in cycle k+1, with mem_waddr set to the cycle-k mar_in shifted left by 2 and mem_wdata set to the cycle-k mdr_in. mdr_load stays 0.
- R6: A fetch in cycle k drives mem_fetch=1 and mbr_load=1 in cycle k+1. mem_baddr equals the cycle-k pc_in unshifted, and mbr_data carries the addressed byte. The memory holds bytes little-endian within a word, so byte address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of word a/4.
- R7: A fetch and a word read or write issued in the same cycle both complete in cycle k+1 without affecting each other.
- R8: A read and a write requested in the same cycle raise req_conflict=1 in cycle k+1 and issue neither mem_rd nor mem_wr. mem_rd and mem_wr are never 1 together.
- R9: Changes to mar_in, mdr_in or pc_in in cycle k+1 do not alter an access that was issued in cycle k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Word read request from the microinstruction |
| wr_req | input | 1 | Word write request from the microinstruction |
| fetch_req | input | 1 | Byte fetch request from the microinstruction |
| mar_in | input | 32 | Word address register contents |
| mdr_in | input | 32 | Data register contents (write data) |
| pc_in | input | 32 | Program counter (byte address) |
| mem_waddr | output | 32 | Byte address for the word access |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_wdata | output | 32 | Word write data |
| mem_rdata | input | 32 | Word returned by memory |
| mem_baddr | output | 32 | Byte address for the fetch |
| mem_fetch | output | 1 | Fetch strobe |
| mem_bdata | input | 8 | Byte returned by memory |
| mdr_load | output | 1 | Load pulse for the data register |
| mdr_data | output | 32 | Value to load into the data register |
| mbr_load | output | 1 | Load pulse for the byte buffer |
| mbr_data | output | 8 | Value to load into the byte buffer |
| req_conflict | output | 1 | Read and write were requested together |

## Verification
The two paths that can act in the same cycle are a word read or write and a byte fetch. Both can also coincide with a data-register load caused by the read one cycle earlier. The bench issues read, write and fetch in the same microinstruction, and back-to-back with addresses changed immediately after issue. A behavioural model predicts, cycle by cycle, every strobe, address and load pulse, and it tracks a modelled data register so that stale and fresh contents are both checked.

// File: rtl/mp_pkg.sv
package mp_pkg;
   typedef enum logic [1:0] {
      WOP_IDLE  = 2'd0,
      WOP_READ  = 2'd1,
      WOP_WRITE = 2'd2
   } word_op_e;
endpackage

// File: rtl/mp_req_check.sv
module mp_req_check
   import mp_pkg::*;
(
   input  logic     rd_i,
   input  logic     wr_i,
   output word_op_e op_o,
   output logic     conflict_o
);
   always_comb begin
      conflict_o = rd_i & wr_i;
      if (rd_i && !wr_i)      op_o = WOP_READ;
      else if (wr_i && !rd_i) op_o = WOP_WRITE;
      else                    op_o = WOP_IDLE;
   end
endmodule

// File: rtl/mp_word_chan.sv
module mp_word_chan
   import mp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SHIFT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  word_op_e          op_i,
   input  logic              conflict_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [ADDR_W-1:0] mem_waddr_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              mdr_load_o,
   output logic [DATA_W-1:0] mdr_data_o,
   output logic              err_o
);
   word_op_e          op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= WOP_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         op_q  <= op_i;
         err_q <= conflict_i;
         if (op_i != WOP_IDLE) addr_q <= addr_i;
         if (op_i == WOP_WRITE) wdata_q <= wdata_i;
      end
   end

   generate
      if (SHIFT == 0) begin : g_noshift
         assign mem_waddr_o = addr_q;
      end else begin : g_shift
         assign mem_waddr_o = {addr_q[ADDR_W-1-SHIFT:0], {SHIFT{1'b0}}};
      end
   endgenerate

   assign mem_rd_o    = (op_q == WOP_READ);
   assign mem_wr_o    = (op_q == WOP_WRITE);
   assign mem_wdata_o = wdata_q;
   assign mdr_load_o  = (op_q == WOP_READ);
   assign mdr_data_o  = mem_rdata_i;
   assign err_o       = err_q;

   assert_read_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == WOP_READ) |=> (mem_rd_o && mem_waddr_o == ($past(addr_i) << SHIFT)));

   assert_load_from_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mdr_load_o |-> ($past(op_i) == WOP_READ));

   assert_write_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == WOP_WRITE) |=> (mem_wr_o && !mdr_load_o && mem_wdata_o == $past(wdata_i)));

   assert_conflict_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      conflict_i |=> (err_o && !mem_rd_o && !mem_wr_o));

   assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));
endmodule

// File: rtl/mp_byte_chan.sv
module mp_byte_chan #(
   parameter int ADDR_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_i,
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] mem_baddr_o,
   output logic              mem_fetch_o,
   input  logic [BYTE_W-1:0] mem_bdata_i,
   output logic              mbr_load_o,
   output logic [BYTE_W-1:0] mbr_data_o
);
   logic              busy_q;
   logic [ADDR_W-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pc_q   <= '0;
      end else begin
         busy_q <= fetch_i;
         if (fetch_i) pc_q <= pc_i;
      end
   end

   assign mem_baddr_o = pc_q;
   assign mem_fetch_o = busy_q;
   assign mbr_load_o  = busy_q;
   assign mbr_data_o  = mem_bdata_i;

   assert_fetch_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_i |=> (mem_fetch_o && mbr_load_o && mem_baddr_o == $past(pc_i)));

   assert_no_spurious_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_i |=> !mbr_load_o);
endmodule

// File: rtl/mem_port_pipe.sv
module mem_port_pipe
   import mp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int BYTE_W     = 8,
   parameter int DATA_W     = WORD_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] mar_in,
   input  logic [DATA_W-1:0] mdr_in,
   input  logic [ADDR_W-1:0] pc_in,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_baddr,
   output logic              mem_fetch,
   input  logic [BYTE_W-1:0] mem_bdata,
   output logic              mdr_load,
   output logic [DATA_W-1:0] mdr_data,
   output logic              mbr_load,
   output logic [BYTE_W-1:0] mbr_data,
   output logic              req_conflict
);
   localparam int SHIFT = $clog2(WORD_BYTES);

   generate
      if (DATA_W != WORD_BYTES * BYTE_W) begin : g_bad_width
         $error("DATA_W must equal WORD_BYTES*BYTE_W");
      end
      if ((1 << SHIFT) != WORD_BYTES) begin : g_bad_bytes
         $error("WORD_BYTES must be a power of two");
      end
      if (SHIFT >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W too small for the byte shift");
      end
   endgenerate

   word_op_e op;
   logic     conflict;

   mp_req_check u_req (
      .rd_i      (rd_req),
      .wr_i      (wr_req),
      .op_o      (op),
      .conflict_o(conflict)
   );

   mp_word_chan #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .SHIFT (SHIFT)
   ) u_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .conflict_i (conflict),
      .addr_i     (mar_in),
      .wdata_i    (mdr_in),
      .mem_waddr_o(mem_waddr),
      .mem_rd_o   (mem_rd),
      .mem_wr_o   (mem_wr),
      .mem_wdata_o(mem_wdata),
      .mem_rdata_i(mem_rdata),
      .mdr_load_o (mdr_load),
      .mdr_data_o (mdr_data),
      .err_o      (req_conflict)
   );

   mp_byte_chan #(
      .ADDR_W(ADDR_W),
      .BYTE_W(BYTE_W)
   ) u_byte (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_i    (fetch_req),
      .pc_i       (pc_in),
      .mem_baddr_o(mem_baddr),
      .mem_fetch_o(mem_fetch),
      .mem_bdata_i(mem_bdata),
      .mbr_load_o (mbr_load),
      .mbr_data_o (mbr_data)
   );

   assert_fetch_indep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && rd_req && !wr_req) |=> (mem_fetch && mem_rd && mdr_load && mbr_load));
endmodule

// File: tb/mem_port_pipe_tb_top.sv
module mem_port_pipe_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_req = 1'b0, wr_req = 1'b0, fetch_req = 1'b0;
   logic [31:0] mar_in = '0, mdr_in = '0, pc_in = '0;
   logic [31:0] mem_waddr, mem_wdata, mem_rdata, mem_baddr, mdr_data;
   logic        mem_rd, mem_wr, mem_fetch, mdr_load, mbr_load, req_conflict;
   logic [7:0]  mem_bdata, mbr_data;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] mem [64];
   logic [31:0] dp_mdr = '0;
   logic [31:0] model_mdr = '0;

   // expectations for the cycle after the one being issued
   logic        e_rd = 0, e_wr = 0, e_f = 0, e_err = 0;
   logic [31:0] e_waddr = 0, e_wdata = 0, e_baddr = 0;

   always #10 clk = ~clk;

   mem_port_pipe dut_i (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req),
      .mar_in(mar_in), .mdr_in(mdr_in), .pc_in(pc_in),
      .mem_waddr(mem_waddr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_baddr(mem_baddr), .mem_fetch(mem_fetch),
      .mem_bdata(mem_bdata), .mdr_load(mdr_load), .mdr_data(mdr_data),
      .mbr_load(mbr_load), .mbr_data(mbr_data), .req_conflict(req_conflict)
   );

   // memory model
   logic [31:0] bword;
   assign mem_rdata = mem_rd ? mem[mem_waddr[7:2]] : 32'h0;
   assign bword     = mem[mem_baddr[7:2]];
   assign mem_bdata = mem_fetch ? bword[8*mem_baddr[1:0] +: 8] : 8'h0;

   always @(posedge clk) begin
      if (mem_wr) mem[mem_waddr[7:2]] <= mem_wdata;
      if (mdr_load) dp_mdr <= mdr_data;
   end

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // compare previous expectation, then issue a new request
   task automatic step(input logic rd, input logic wr, input logic f,
                       input logic [31:0] a, input logic [31:0] d, input logic [31:0] p,
                       input string req);
      logic [31:0] w;
      @(negedge clk);
      chk(req, "dp_mdr", dp_mdr, model_mdr);
      chk(req, "mem_rd", {31'b0, mem_rd}, {31'b0, e_rd});
      chk(req, "mem_wr", {31'b0, mem_wr}, {31'b0, e_wr});
      chk(req, "mdr_load", {31'b0, mdr_load}, {31'b0, e_rd});
      chk(req, "mem_fetch", {31'b0, mem_fetch}, {31'b0, e_f});
      chk(req, "mbr_load", {31'b0, mbr_load}, {31'b0, e_f});
      chk(req, "req_conflict", {31'b0, req_conflict}, {31'b0, e_err});
      if (e_rd || e_wr) chk(req, "mem_waddr", mem_waddr, e_waddr);
      if (e_wr) chk(req, "mem_wdata", mem_wdata, e_wdata);
      if (e_rd) begin
         chk(req, "mdr_data", mdr_data, mem[e_waddr[7:2]]);
         model_mdr = mem[e_waddr[7:2]];
      end
      if (e_f) begin
         w = mem[e_baddr[7:2]];
         chk(req, "mem_baddr", mem_baddr, e_baddr);
         chk(req, "mbr_data", {24'b0, mbr_data}, {24'b0, w[8*e_baddr[1:0] +: 8]});
      end
      rd_req = rd; wr_req = wr; fetch_req = f;
      mar_in = a; mdr_in = d; pc_in = p;
      e_rd = rd & ~wr; e_wr = wr & ~rd; e_err = rd & wr; e_f = f;
      e_waddr = a << 2; e_wdata = d; e_baddr = p;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + 32'(i * 32'h0101_0103);
   end

   initial begin
      fork
         begin
            repeat (5) @(negedge clk);
            // R1: reset state
            chk("R1", "mem_rd", {31'b0, mem_rd}, 0);
            chk("R1", "mem_wr", {31'b0, mem_wr}, 0);
            chk("R1", "mem_fetch", {31'b0, mem_fetch}, 0);
            chk("R1", "mdr_load", {31'b0, mdr_load}, 0);
            chk("R1", "mbr_load", {31'b0, mbr_load}, 0);
            chk("R1", "req_conflict", {31'b0, req_conflict}, 0);
            rst_n = 1'b1;
            // R2 R3: single read, register stale one cycle
            step(1, 0, 0, 32'd5, 0, 0, "R2");
            step(0, 0, 0, 0, 0, 0, "R3");
            step(0, 0, 0, 0, 0, 0, "R3");
            // R4: back-to-back reads
            step(1, 0, 0, 32'd7, 0, 0, "R4");
            step(1, 0, 0, 32'd9, 0, 0, "R4");
            step(0, 0, 0, 0, 0, 0, "R4");
            step(0, 0, 0, 0, 0, 0, "R4");
            // R5: write then read back same word
            step(0, 1, 0, 32'd12, 32'hDEAD_BEEF, 0, "R5");
            step(1, 0, 0, 32'd12, 32'h1111_1111, 0, "R5");
            step(0, 0, 0, 0, 0, 0, "R5");
            // R6: fetches at each byte lane
            for (int b = 0; b < 4; b++) step(0, 0, 1, 0, 0, 32'(40 + b), "R6");
            step(0, 0, 0, 0, 0, 0, "R6");
            // R7: fetch with read, then fetch with write
            step(1, 0, 1, 32'd20, 0, 32'd83, "R7");
            step(0, 1, 1, 32'd21, 32'h0BAD_F00D, 32'd86, "R7");
            step(1, 0, 0, 32'd21, 0, 0, "R7");
            step(0, 0, 0, 0, 0, 0, "R7");
            // R8: read and write together
            step(1, 1, 0, 32'd30, 32'h5555_AAAA, 0, "R8");
            step(1, 0, 0, 32'd30, 0, 0, "R8");
            step(0, 0, 0, 0, 0, 0, "R8");
            // R9: inputs change right after issue
            step(1, 0, 1, 32'd33, 0, 32'd17, "R9");
            step(0, 0, 0, 32'd50, 32'hFFFF_FFFF, 32'd99, "R9");
            step(0, 1, 0, 32'd34, 32'h1234_5678, 0, "R9");
            step(0, 0, 0, 32'd35, 32'h8765_4321, 0, "R9");
            step(1, 0, 0, 32'd34, 0, 0, "R9");
            // mixed stream
            for (int i = 0; i < 40; i++)
               step(i % 3 == 0, i % 5 == 1, i % 2 == 0, 32'(i % 60), 32'(i * 32'h0F0F_1234),
                    32'(i * 7 % 250), "R7");
            step(0, 0, 0, 0, 0, 0, "R4");
            step(0, 0, 0, 0, 0, 0, "R4");
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule